// File: doc/BRIEF.md
# Host Frame Timer With Start-of-Frame Strobe

This block paces the frames of a USB host port. When the port becomes enabled it loads a programmable frame interval, given in clock cycles, into a down-counter. It counts down once per cycle and raises a one-cycle start-of-frame request for the transaction layer each time the count reaches zero. It then reloads and starts the next frame. The nominal interval is 48000 cycles, which gives 1 ms at a 48 MHz USB clock. Software can rewrite the interval at any time to trim the frame length, and the new value is picked up at the next reload.

The remaining-cycle count and an 11-bit frame number are presented as plain status outputs. While the port is suspended the count freezes and no requests are issued. When the port leaves the enabled state the counter and the frame number return to zero. An optional pin output gives a fixed 12-cycle pulse for every start-of-frame, gated by an enable bit. The block runs in a single clock domain: the USB clock and the pulse clock are the same `clk`. All pins are level or strobe controls with no back-pressure, because the transaction layer must take every request in the cycle it is raised.

Top module: `sof_frame_timer`

## Requirements
- R1: After reset, `remain_cnt`, `frame_num`, `sof_req` and `sof_pin` are 0 and the stored interval is 48000.
- R2: The first cycle in which `port_enabled` is seen high after being low is the entry cycle. In the next cycle `remain_cnt` equals interval-1, and the first `sof_req` comes exactly interval cycles after the entry cycle.
- R3: In a running cycle (enabled, not suspended, past entry), a nonzero `remain_cnt` drops by one. When it is zero, `sof_req` is 1 for that cycle and the count reloads to interval-1 in the next cycle, so requests are spaced interval cycles apart.
- R4: An interval write (`intv_wr`=1 with `intv_wdata`) leaves the frame in progress unchanged. It is used from the next reload on.
- R5: While `port_suspended` is 1, `sof_req` is 0 and `remain_cnt` and `frame_num` hold their values.
- R6: `frame_num` increases by one in the cycle after each `sof_req` and wraps from 2047 to 0.
- R7: In the cycle after `port_enabled` is seen low, `remain_cnt` and `frame_num` are 0, and `sof_req` is 0 whenever `port_enabled` is 0.
- R8: If `sof_out_en` is 1 in a `sof_req` cycle, `sof_pin` is high for the following 12 cycles. With `sof_out_en` at 0, a request starts no pulse.
- R9: A request during a pulse restarts the 12-cycle count. `sof_pin` is low in the cycle after `sof_out_en` is seen low.
- R10: An interval of 0 behaves as 1: a request in every running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the counter and the pulse |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_enabled | input | 1 | Port controller reports the port enabled |
| port_suspended | input | 1 | Port controller reports the port suspended |
| intv_wr | input | 1 | Write strobe for the frame interval |
| intv_wdata | input | CNT_W | New frame interval in clock cycles |
| sof_out_en | input | 1 | Enables the start-of-frame pin pulse |
| sof_req | output | 1 | One-cycle start-of-frame request |
| remain_cnt | output | CNT_W | Cycles left in the current frame |
| frame_num | output | 11 | Frame number |
| sof_pin | output | 1 | 12-cycle pulse for the pin |

## Verification
The assertions take `port_enabled`, `port_suspended` and `sof_out_en` to be synchronous levels that hold steady across each clock edge. They also assume that suspend is asserted only while the port is enabled, since a suspended but disabled port is cleared by the disabled rule. The bench drives every input just after the falling edge. Its random phase toggles enable, suspend, writes and the pin enable at low rates, with intervals of 0 to 19, so that pulses overlap, intervals degenerate and frame boundaries fall in suspend. The bench model follows the requirements for every such pattern.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int FNUM_W = 11;
  localparam int DEF_PULSE_LEN = 12;
  typedef logic [FNUM_W-1:0] fnum_t;
endpackage

// File: rtl/sft_interval_reg.sv
module sft_interval_reg #(
  parameter int CNT_W = 16,
  parameter int DEF_INTV = 48000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] reload_val
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(DEF_INTV);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] intv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intv_q <= RST_VAL;
    else if (wr_en) intv_q <= wr_data;
  end

  // a frame of N cycles counts N-1 down to 0; zero is treated as one
  always_comb begin
    if (intv_q == '0) reload_val = '0;
    else reload_val = intv_q - ONE;
  end
endmodule

// File: rtl/sft_remain_ctr.sv
module sft_remain_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enabled,
  input  logic             suspended,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] remain,
  output logic             en_q,
  output logic             sof
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic running;
  assign running = en_q && enabled && !suspended;
  assign sof     = running && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= enabled;
      if (!enabled) remain <= '0;
      else if (!en_q) remain <= reload_val;
      else if (running) begin
        if (remain == '0) remain <= reload_val;
        else remain <= remain - ONE;
      end
    end
  end
endmodule

// File: rtl/sft_frame_ctr.sv
module sft_frame_ctr
  import sft_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enabled,
  input  logic  sof,
  output fnum_t fnum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fnum <= '0;
    else if (!enabled) fnum <= '0;
    else if (sof) fnum <= fnum + 1'b1;
  end
endmodule

// File: rtl/sft_pulse_gen.sv
module sft_pulse_gen #(
  parameter int LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic out_en,
  output logic pin
);
  localparam int PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] START = PW'(LEN);
  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else if (!out_en) left_q <= '0;
    else if (trig) left_q <= START;
    else if (left_q != '0) left_q <= left_q - ONE;
  end

  assign pin = (left_q != '0);
endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer
  import sft_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEF_INTV = 48000,
  parameter int PULSE_LEN = DEF_PULSE_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_enabled,
  input  logic             port_suspended,
  input  logic             intv_wr,
  input  logic [CNT_W-1:0] intv_wdata,
  input  logic             sof_out_en,
  output logic             sof_req,
  output logic [CNT_W-1:0] remain_cnt,
  output logic [10:0]      frame_num,
  output logic             sof_pin
);
  logic [CNT_W-1:0] reload_val;
  logic             en_q;
  fnum_t            fnum;

  sft_interval_reg #(.CNT_W(CNT_W), .DEF_INTV(DEF_INTV)) u_intv (
    .clk(clk), .rst_n(rst_n), .wr_en(intv_wr), .wr_data(intv_wdata),
    .reload_val(reload_val)
  );

  sft_remain_ctr #(.CNT_W(CNT_W)) u_rem (
    .clk(clk), .rst_n(rst_n), .enabled(port_enabled),
    .suspended(port_suspended), .reload_val(reload_val),
    .remain(remain_cnt), .en_q(en_q), .sof(sof_req)
  );

  sft_frame_ctr u_fnum (
    .clk(clk), .rst_n(rst_n), .enabled(port_enabled), .sof(sof_req),
    .fnum(fnum)
  );
  assign frame_num = fnum;

  sft_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(sof_req), .out_en(sof_out_en),
    .pin(sof_pin)
  );
endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_enabled,
  input logic             port_suspended,
  input logic             sof_out_en,
  input logic             en_q,
  input logic             sof_req,
  input logic [CNT_W-1:0] remain_cnt,
  input logic [10:0]      frame_num,
  input logic             sof_pin
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (port_enabled && $past(en_q && port_enabled && !port_suspended && remain_cnt != '0))
      |-> remain_cnt == ($past(remain_cnt) - ONE));

  a_r5_no_sof_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    port_suspended |-> !sof_req);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && port_enabled && port_suspended) |=>
      (!port_enabled || ($stable(remain_cnt) && $stable(frame_num))));

  a_r6_frame_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_req && port_enabled) |=> frame_num == 11'($past(frame_num) + 11'd1));

  a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !port_enabled |=> (frame_num == '0 && remain_cnt == '0));

  a_r7_no_sof_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !port_enabled |-> !sof_req);

  a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_req && sof_out_en) |=> sof_pin);

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_pin) |-> $past(sof_req && sof_out_en));

  a_r9_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_out_en |=> !sof_pin);
endmodule

bind sof_frame_timer sft_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_enabled(port_enabled),
  .port_suspended(port_suspended), .sof_out_en(sof_out_en), .en_q(en_q),
  .sof_req(sof_req), .remain_cnt(remain_cnt), .frame_num(frame_num),
  .sof_pin(sof_pin)
);

// File: tb/sim_sof_frame_timer.sv
module sim_sof_frame_timer;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam int PLEN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sus = 1'b0, wr = 1'b0, pen = 1'b0;
  logic [CNT_W-1:0] wd = '0;
  logic sof_req, sof_pin;
  logic [CNT_W-1:0] remain_cnt;
  logic [10:0] frame_num;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference state, built from the requirements
  int m_intv, m_rem, m_fn, m_pc;
  bit m_enq;

  always #(CLK_P/2) clk = ~clk;

  sof_frame_timer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .port_enabled(en), .port_suspended(sus),
    .intv_wr(wr), .intv_wdata(wd), .sof_out_en(pen), .sof_req(sof_req),
    .remain_cnt(remain_cnt), .frame_num(frame_num), .sof_pin(sof_pin)
  );

  function automatic int reload_of(int iv);
    return (iv == 0) ? 0 : iv - 1;
  endfunction

  function automatic bit exp_sof();
    return m_enq && en && !sus && (m_rem == 0);
  endfunction

  task automatic chk(input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_intv = 48000; m_rem = 0; m_fn = 0; m_pc = 0; m_enq = 0;
  endtask

  // one cycle: compare, advance the model, move to the next falling edge
  task automatic tick();
    bit s;
    int n_rem, n_fn, n_pc;
    #1;
    s = exp_sof();
    chk("sof_req(R3)", sof_req, s);
    chk("remain(R3)", remain_cnt, m_rem);
    chk("frame_num(R6)", frame_num, m_fn);
    chk("sof_pin(R8)", sof_pin, m_pc != 0);
    n_rem = m_rem; n_fn = m_fn; n_pc = m_pc;
    if (!en) begin n_rem = 0; n_fn = 0; end
    else if (!m_enq) n_rem = reload_of(m_intv);
    else if (!sus) n_rem = (m_rem == 0) ? reload_of(m_intv) : m_rem - 1;
    if (en && s) n_fn = (m_fn + 1) % 2048;
    if (!pen) n_pc = 0;
    else if (s) n_pc = PLEN;
    else if (m_pc != 0) n_pc = m_pc - 1;
    @(posedge clk);
    m_rem = n_rem; m_fn = n_fn; m_pc = n_pc; m_enq = en;
    if (wr) m_intv = int'(wd);
    @(negedge clk);
  endtask

  task automatic write_intv(input int v);
    wr = 1'b1; wd = CNT_W'(v); tick(); wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    chk("reset remain R1", remain_cnt, 0);
    chk("reset frame_num R1", frame_num, 0);
    chk("reset sof_req R1", sof_req, 0);
    chk("reset sof_pin R1", sof_pin, 0);
    rst_n = 1'b1;
    tick();

    // R1/R2: default interval gives the first request 48000 cycles after entry
    tag = "R2";
    en = 1'b1; tick();
    #1 chk("R2 default remain after entry", remain_cnt, 47999);
    repeat (47999) tick();
    #1 chk("R2 first sof at default interval", sof_req, 1);
    tick();
    #1 chk("R6 frame after first sof", frame_num, 1);

    // R7: leaving enabled clears state
    tag = "R7";
    en = 1'b0; tick();
    #1 chk("R7 remain cleared", remain_cnt, 0);
    chk("R7 frame cleared", frame_num, 0);
    repeat (3) tick();

    // R2: short programmed interval
    tag = "R2";
    write_intv(7);
    en = 1'b1; tick();
    #1 chk("R2 remain after entry", remain_cnt, 6);
    repeat (6) tick();
    #1 chk("R2 sof after 7 cycles", sof_req, 1);
    tick();
    #1 chk("R3 reload after sof", remain_cnt, 6);

    // R4: write mid-frame leaves current frame alone
    tag = "R4";
    repeat (2) tick();
    write_intv(3);
    #1 chk("R4 old count continues", remain_cnt, 3);
    repeat (3) tick();
    #1 chk("R4 old frame ends", sof_req, 1);
    tick();
    #1 chk("R4 new interval after reload", remain_cnt, 2);
    repeat (10) tick();

    // R5: suspend freezes count
    tag = "R5";
    sus = 1'b1;
    repeat (8) tick();
    sus = 1'b0;
    repeat (10) tick();

    // R8/R9: pulse with overlap and gating
    tag = "R8";
    pen = 1'b1; write_intv(20);
    repeat (45) tick();
    tag = "R9";
    write_intv(5);
    repeat (40) tick();
    pen = 1'b0; tick();
    #1 chk("R9 pin low after enable cleared", sof_pin, 0);
    repeat (5) tick();

    // R10 and R6: interval 0, wrap of frame number
    tag = "R10";
    write_intv(0);
    repeat (10) tick();
    tag = "R6";
    for (int i = 0; i < 2100 && frame_num != 11'd2047; i++) tick();
    #1 chk("R6 reached 2047", frame_num, 2047);
    tick();
    #1 chk("R6 wrap to 0", frame_num, 0);

    // random mix
    tag = "RND";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 60 == 0) en = ~en;
      if ($urandom % 40 == 0) sus = ~sus;
      if (!en) sus = 1'b0;
      if ($urandom % 50 == 0) pen = ~pen;
      wr = ($urandom % 30 == 0);
      wd = CNT_W'($urandom % 20);
      tick();
    end
    wr = 1'b0;
    finish_run();
  end
endmodule